// File: doc/BRIEF.md
# Break-Capable UART Transmitter

An asynchronous serial transmitter built from a one-byte holding register feeding a frame shifter. The host loads a byte through a write strobe, and the shifter sends it as a ten-bit frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. One bit goes out per baud tick. An external baud-rate generator supplies the tick. The same shifter can also send two other kinds of frame. A preamble frame is ten bit-times of mark (logic 1). A break frame is ten bit-times of space (logic 0).

The empty flag needs a handshake. The host first pulses an acknowledge strobe while the flag is set, and only then does a write count as a new byte. A write that skips this step is dropped. A write made while a byte is still waiting replaces that byte. The break control is a level. The frame already on the line always finishes first. After it, break frames go out back to back for as long as the level stays high. The complete flag rises only when nothing at all is left to send.

Top module: `brk_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_done` is 1. Whenever no frame is being shifted, `txd` stays 1.
- R2: A data frame is ten bit-times, one bit per `baud_tick`. It is a 0 start bit, then `wr_data[0]` up to `wr_data[7]`, then a 1 stop bit. When the shifter loads from idle, the start bit appears at the first tick after the load.
- R3: `hold_empty` becomes 1 in the cycle the held byte moves into the shifter. It becomes 0 when a write follows an `empty_ack` pulse that was given while `hold_empty` was 1.
- R4: A write while `hold_empty` is 0 replaces the waiting byte. Only the last byte written is sent.
- R5: A write while `hold_empty` is 1, with no `empty_ack` since the flag last rose, is ignored. No frame is sent, the flag stays 1, and a later accepted byte goes out unchanged.
- R6: While `brk_hold` is 1, the frame in progress completes unaltered. After it, all-zero ten-bit frames follow with no gap until `brk_hold` falls.
- R7: A `brk_hold` pulse shorter than one frame time causes one or two break frames. A one-cycle pulse on an idle line causes exactly one.
- R8: A one-cycle `pre_req` queues one preamble: ten bit-times of 1 during which `tx_done` stays 0.
- R9: `tx_done` falls when the shifter loads any frame. It rises only when a frame ends with no byte, preamble or break waiting. Each frame therefore holds it low for exactly ten ticks.
- R10: At a frame boundary a waiting break goes first, then a queued preamble, then a waiting data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Byte to write |
| empty_ack | input | 1 | Acknowledge of the set empty flag; arms the next write |
| brk_hold | input | 1 | Level request for break frames |
| pre_req | input | 1 | One-cycle request to queue an idle preamble |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmitter complete flag |

## Verification
The bench builds the block with its default eight-bit data width. That gives ten-bit frames, and the bench drives a baud tick every fourth clock. A frame therefore lasts about forty cycles. Short break pulses of random length and position can then land before, inside or across a frame boundary. Back-to-back data, preamble and break frames all fit in one short run. A line monitor decodes each frame as nine sampled bits. Frame timing is checked from the count of ticks during which the complete flag is low.

// File: rtl/brk_uart_pkg.sv
package brk_uart_pkg;

    localparam int DEF_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT
    } tx_state_e;

    typedef enum logic [1:0] {
        K_DATA,
        K_PRE,
        K_BRK
    } frame_kind_e;

    // Boundary priority: break, then preamble, then data.
    function automatic frame_kind_e pick_kind(input logic brk, input logic pre);
        if (brk)      return K_BRK;
        else if (pre) return K_PRE;
        else          return K_DATA;
    endfunction

endpackage

// File: rtl/brk_uart_hold.sv
module brk_uart_hold #(
    parameter int DATA_W = brk_uart_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack,
    input  logic              take,
    output logic              hre,
    output logic [DATA_W-1:0] data
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            hre   <= 1'b1;
            armed <= 1'b0;
            data  <= '0;
        end else begin
            if (take) begin
                hre <= 1'b1;
            end else if (wr_stb && (!hre || armed)) begin
                data <= wr_data;
                hre  <= 1'b0;
            end
            if (ack && hre)
                armed <= 1'b1;
            if (wr_stb && hre && armed && !take)
                armed <= 1'b0;
        end
    end

    p_hre_set_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> hre);

    p_unarmed_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && hre && !armed) |=> (hre && data == $past(data)));

endmodule

// File: rtl/brk_uart_queue.sv
module brk_uart_queue (
    input  logic clk,
    input  logic rst,
    input  logic brk_lvl,
    input  logic pre_req,
    input  logic take_brk,
    input  logic take_pre,
    output logic brk_pend,
    output logic pre_pend
);
    logic brk_seen;
    logic pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_seen <= 1'b0;
            pre_q    <= 1'b0;
        end else begin
            brk_seen <= take_brk ? 1'b0 : (brk_seen | brk_lvl);
            pre_q    <= take_pre ? pre_req : (pre_q | pre_req);
        end
    end

    assign brk_pend = brk_seen | brk_lvl;
    assign pre_pend = pre_q;

    p_pre_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (pre_q && !take_pre) |=> pre_q);

    p_brk_latched_r7: assert property (@(posedge clk) disable iff (rst)
        (brk_lvl && !take_brk) |=> brk_pend);

endmodule

// File: rtl/brk_uart_shift.sv
module brk_uart_shift
    import brk_uart_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              brk_pend,
    input  logic              pre_pend,
    input  logic              dat_pend,
    input  logic [DATA_W-1:0] data,
    output logic              take_brk,
    output logic              take_pre,
    output logic              take_dat,
    output logic              txd,
    output logic              done
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    tx_state_e          st;
    frame_kind_e        kind, kind_n;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] frm, frame_n;
    logic               any, boundary, load;

    always_comb begin
        any      = brk_pend | pre_pend | dat_pend;
        kind_n   = pick_kind(brk_pend, pre_pend);
        boundary = (st == ST_SHIFT) && tick && (cnt == LAST);
        load     = any && ((st == ST_IDLE) || boundary);
        case (kind_n)
            K_BRK:   frame_n = '0;
            K_PRE:   frame_n = '1;
            default: frame_n = {1'b1, data, 1'b0};
        endcase
        take_brk = load && (kind_n == K_BRK);
        take_pre = load && (kind_n == K_PRE);
        take_dat = load && (kind_n == K_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            kind <= K_DATA;
            cnt  <= '0;
            frm  <= '1;
            txd  <= 1'b1;
            done <= 1'b1;
        end else begin
            case (st)
                ST_IDLE: if (load) begin
                    frm  <= frame_n;
                    kind <= kind_n;
                    st   <= ST_WAIT;
                    done <= 1'b0;
                end
                ST_WAIT: if (tick) begin
                    st  <= ST_SHIFT;
                    cnt <= '0;
                    txd <= frm[0];
                end
                default: if (tick) begin
                    if (cnt == LAST) begin
                        if (load) begin
                            frm  <= frame_n;
                            kind <= kind_n;
                            cnt  <= '0;
                            txd  <= frame_n[0];
                        end else begin
                            st   <= ST_IDLE;
                            txd  <= 1'b1;
                            done <= 1'b1;
                        end
                    end else begin
                        frm <= frm >> 1;
                        txd <= frm[1];
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    p_line_high_r1: assert property (@(posedge clk) disable iff (rst)
        (st != ST_SHIFT) |-> txd);

    p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && kind == K_DATA && cnt == LAST) |-> txd);

    p_break_low_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && kind == K_BRK) |-> !txd);

    p_preamble_high_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && kind == K_PRE) |-> txd);

    p_done_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(!brk_pend && !pre_pend && !dat_pend));

    p_done_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(st == ST_IDLE));

    p_single_take_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_brk, take_pre, take_dat}));

endmodule

// File: rtl/brk_uart_tx.sv
module brk_uart_tx
    import brk_uart_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              empty_ack,
    input  logic              brk_hold,
    input  logic              pre_req,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_done
);
    logic              take_brk, take_pre, take_dat;
    logic              brk_pend, pre_pend;
    logic [DATA_W-1:0] held;

    brk_uart_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .ack     (empty_ack),
        .take    (take_dat),
        .hre     (hold_empty),
        .data    (held)
    );

    brk_uart_queue u_queue (
        .clk      (clk),
        .rst      (rst),
        .brk_lvl  (brk_hold),
        .pre_req  (pre_req),
        .take_brk (take_brk),
        .take_pre (take_pre),
        .brk_pend (brk_pend),
        .pre_pend (pre_pend)
    );

    brk_uart_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .brk_pend (brk_pend),
        .pre_pend (pre_pend),
        .dat_pend (!hold_empty),
        .data     (held),
        .take_brk (take_brk),
        .take_pre (take_pre),
        .take_dat (take_dat),
        .txd      (txd),
        .done     (tx_done)
    );

endmodule

// File: tb/sim_brk_uart_tx.sv
`timescale 1ns/1ps
module sim_brk_uart_tx;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0, rst = 1'b1, baud_tick = 1'b0;
    logic       wr_stb = 1'b0, empty_ack = 1'b0, brk_hold = 1'b0, pre_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, hold_empty, tx_done;

    always #2.5 clk = ~clk;

    brk_uart_tx #(.DATA_W(8)) u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_stb(wr_stb),
        .wr_data(wr_data), .empty_ack(empty_ack), .brk_hold(brk_hold),
        .pre_req(pre_req), .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
    );

    int checks = 0, errors = 0;
    int tdiv = 0, tk = 0, nfr = 0, nb = 0, lowticks = 0, t_first = 0;
    logic [8:0] flog [0:511];
    int         fstart [0:511];
    logic [8:0] sh = '0;
    logic in_fr = 1'b0, done_prev = 1'b1, fall_pend = 1'b0;

    // Line monitor: samples txd after every tick edge, decodes {stop, data}.
    always @(negedge clk) begin
        if (!rst && baud_tick) begin
            tk++;
            if (fall_pend) begin t_first = tk; fall_pend = 1'b0; end
            if (!tx_done && !done_prev) lowticks++;
            if (!in_fr) begin
                if (txd == 1'b0) begin
                    in_fr = 1'b1; nb = 0;
                    if (nfr < 512) fstart[nfr] = tk;
                end
            end else begin
                sh[nb] = txd; nb++;
                if (nb == 9) begin
                    if (nfr < 512) flog[nfr] = sh;
                    nfr++; in_fr = 1'b0;
                end
            end
        end
        if (!rst && done_prev && !tx_done) fall_pend = 1'b1;
        done_prev = tx_done;
        tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_ack();
        empty_ack = 1'b1; @(negedge clk); empty_ack = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_stb = 1'b1; wr_data = b; @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        while (!tx_done && n < 4000) begin @(negedge clk); n++; end
        chk(tx_done, "R9 wait for done", tx_done, 1);
    endtask

    function automatic logic [8:0] dframe(input logic [7:0] b);
        return {1'b1, b};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, nbrk, bad, n, npre;
        logic [7:0] b;
        logic [7:0] expq [0:63];
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
        chk(tx_done == 1'b1, "R1 tx_done", tx_done, 1);

        // R2/R3/R9 single byte
        base = nfr; lowticks = 0;
        pulse_ack();
        write_byte(8'hA5);
        chk(hold_empty == 1'b0, "R3 empty clears on armed write", hold_empty, 0);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R3 empty sets on transfer", hold_empty, 1);
        chk(tx_done == 1'b0, "R9 done falls on load", tx_done, 0);
        wait_done();
        chk(nfr - base == 1, "R2 frame count", nfr - base, 1);
        chk(flog[base] == dframe(8'hA5), "R2 frame content", flog[base], dframe(8'hA5));
        chk(fstart[base] == t_first, "R2 start at first tick", fstart[base], t_first);
        chk(lowticks == 10, "R9 ten ticks low", lowticks, 10);

        // R5 unarmed write ignored
        base = nfr;
        write_byte(8'h3C);
        repeat (60) @(negedge clk);
        chk(nfr == base, "R5 no frame", nfr - base, 0);
        chk(hold_empty == 1'b1, "R5 empty stays", hold_empty, 1);
        chk(tx_done == 1'b1, "R5 done stays", tx_done, 1);
        pulse_ack();
        write_byte(8'h5A);
        wait_done();
        chk(nfr - base == 1 && flog[base] == dframe(8'h5A), "R5 later byte intact",
            flog[base], dframe(8'h5A));

        // R4/R10 overwrite while break holds data back
        base = nfr;
        brk_hold = 1'b1;
        repeat (10) @(negedge clk);
        pulse_ack();
        write_byte(8'h11);
        write_byte(8'h22);
        chk(hold_empty == 1'b0, "R4 byte still pending", hold_empty, 0);
        repeat (30) @(negedge clk);
        brk_hold = 1'b0;
        wait_done();
        nbrk = nfr - base - 1;
        bad = 0;
        for (int i = 0; i < nbrk; i++) if (flog[base + i] != 9'h000) bad++;
        chk(nbrk >= 1 && bad == 0, "R10 breaks before data", bad, 0);
        chk(flog[nfr - 1] == dframe(8'h22), "R4 last write sent", flog[nfr - 1], dframe(8'h22));

        // R6 break held during a data frame
        base = nfr; lowticks = 0;
        pulse_ack();
        write_byte(8'h81);
        repeat (8) @(negedge clk);
        brk_hold = 1'b1;
        repeat (120) @(negedge clk);
        brk_hold = 1'b0;
        wait_done();
        chk(flog[base] == dframe(8'h81), "R6 current frame completes", flog[base], dframe(8'h81));
        nbrk = nfr - base - 1;
        bad = 0;
        for (int i = 1; i <= nbrk; i++) if (flog[base + i] != 9'h000) bad++;
        chk(nbrk >= 3 && bad == 0, "R6 back-to-back break frames", nbrk, 3);
        chk(lowticks == 10 * (nfr - base), "R6 no gaps", lowticks, 10 * (nfr - base));

        // R7 one-cycle pulse on idle line
        base = nfr;
        brk_hold = 1'b1; @(negedge clk); brk_hold = 1'b0;
        wait_done();
        chk(nfr - base == 1 && flog[base] == 9'h000, "R7 single break", nfr - base, 1);

        // R8/R10 preamble queued with data goes first
        base = nfr; lowticks = 0;
        pulse_ack();
        pre_req = 1'b1; wr_stb = 1'b1; wr_data = 8'hC3;
        @(negedge clk);
        pre_req = 1'b0; wr_stb = 1'b0;
        wait_done();
        chk(nfr - base == 1 && flog[base] == dframe(8'hC3), "R8 preamble sends no zeros",
            flog[base], dframe(8'hC3));
        chk(lowticks == 20, "R8 preamble is ten ticks", lowticks, 20);
        chk(fstart[base] == t_first + 10, "R10 preamble before data", fstart[base], t_first + 10);

        // R7 random short pulses around a data frame
        for (int it = 0; it < 8; it++) begin
            base = nfr;
            b = 8'($urandom);
            pulse_ack();
            write_byte(b);
            repeat (2 + $urandom % 30) @(negedge clk);
            brk_hold = 1'b1;
            repeat (1 + $urandom % 30) @(negedge clk);
            brk_hold = 1'b0;
            wait_done();
            nbrk = nfr - base - 1;
            bad = (flog[base] != dframe(b)) ? 1 : 0;
            for (int i = 1; i <= nbrk; i++) if (flog[base + i] != 9'h000) bad++;
            chk(nbrk >= 1 && nbrk <= 2 && bad == 0, "R7 short pulse gives one or two", nbrk, 1);
        end

        // R2/R9 random data stream with preambles
        base = nfr; lowticks = 0; n = 24; npre = 0;
        for (int i = 0; i < n; i++) begin
            while (!hold_empty) @(negedge clk);
            repeat ($urandom % 50) @(negedge clk);
            if ($urandom % 4 == 0) begin
                pre_req = 1'b1; @(negedge clk); pre_req = 1'b0; npre++;
            end
            b = 8'($urandom);
            expq[i] = b;
            pulse_ack();
            write_byte(b);
        end
        wait_done();
        chk(nfr - base == n, "R2 random frame count", nfr - base, n);
        bad = 0;
        for (int i = 0; i < n; i++) if (flog[base + i] != dframe(expq[i])) bad++;
        chk(bad == 0, "R2 random frame contents", bad, 0);
        chk(lowticks == 10 * (n + npre), "R9 random low ticks", lowticks, 10 * (n + npre));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule